// File: doc/BRIEF.md
# IO Virtual Address Translator

This block turns a device virtual address into a physical address by reading one entry from a single-level page table in memory. Software sets two 32-bit registers through a small register port. The control word holds a 3-bit range code that defines the translation window and an enable flag. The base word locates the page table. A device offers a virtual address on a valid/ready handshake. The block forms the address of the table entry for that page and issues one read on its memory port. When the entry comes back, the block byte-swaps it, extracts the physical page number, adds the page offset and returns the result as a one-cycle response.

Only one translation is in flight at a time. The request side is held off from acceptance until the response has been given. The window start is computed at the moment the control word is written. Entry addresses are formed by clearing the window-start bits of the virtual address, not by subtracting the window start.

Top module: `iova_xlate`

## Requirements
- R1: After a synchronous active-low reset, both registers read 0 and the window start is 0, so no virtual address bits are cleared. After reset `req_ready` is 1 and `rsp_valid` and `mem_req` are 0.
- R2: A write to word 0 stores the full 32-bit control value, and a write to word 1 stores the base value. Both read back on `cfg_rdata` when `cfg_addr` selects them. Writes to words 2 and 3 are ignored, and those words read 0.
- R3: The range code n in control bits 4:2 sets the window start to 2^32 − (2^24 << n). Code 7 gives 0x80000000. The new start applies to every request accepted after the clock edge that takes the write.
- R4: `mem_addr` is (base << 4) + (((va & ~start) >> 10) with bits 1:0 cleared), truncated to 32 bits. `mem_req` is high for exactly one cycle, the cycle after acceptance.
- R5: The entry is held big-endian in memory and the memory port is little-endian, so byte 0 of `mem_rdata` (bits 7:0) is entry bits 31:24, and so on.
- R6: `rsp_pa` is ((entry & 0x07ffff00) << 4) + (va & 0xfff). Entry bits 31:27 and 7:0 have no effect, and PA bit 31 is always 0.
- R7: From acceptance until the response cycle inclusive, `req_ready` is 0. Memory data is taken only when `mem_rvalid` is high at least one cycle after `mem_req`.
- R8: `rsp_valid` is high for exactly one cycle, the cycle after the accepted `mem_rvalid`. `req_ready` returns to 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word select (read and write) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle translation result strobe |
| rsp_pa | output | 32 | Translated physical address |
| mem_req | output | 1 | One-cycle entry read request |
| mem_addr | output | 32 | Byte address of the table entry |
| mem_rvalid | input | 1 | Entry read data valid |
| mem_rdata | input | 32 | Entry data, little-endian port |

## Verification
A wrong window start or base value shows up directly on `mem_addr` in the cycle after the request is accepted. So does a stale register that missed a write. These faults appear before any memory data is returned. A wrong byte order or a wrong page-number mask shows up only on `rsp_pa`, one cycle after memory data arrives. A sequencer that leaves its idle state wrongly shows up as `req_ready` dropping or staying high at the wrong time, or as `rsp_valid` lasting more than one cycle, in the same cycle the state goes wrong.

// File: rtl/iova_pkg.sv
// Shared types for the IO virtual address translator.
package iova_pkg;

    // Sequencer states of the single-outstanding translation walk.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } walk_state_e;

endpackage

// File: rtl/iova_cfg_regs.sv
// Configuration registers: control word, table base word and derived
// window start. Assumes one write per cycle. The window start is recomputed
// from the range field at the same edge that stores the control word.
module iova_cfg_regs #(
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 32,
    parameter int SEL_W        = 2,
    parameter int RANGE_LSB    = 2,
    parameter int RANGE_W      = 3,
    parameter int MIN_WIN_LOG2 = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] base_o,
    output logic [ADDR_W-1:0] win_start_o
);
    localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(0);
    localparam logic [SEL_W-1:0] SEL_BASE = SEL_W'(1);

    logic [DATA_W-1:0]  ctrl_q;
    logic [DATA_W-1:0]  base_q;
    logic [ADDR_W-1:0]  start_q;
    logic [RANGE_W-1:0] range_in;
    logic [ADDR_W-1:0]  start_next;

    // Window start for the incoming range code: all ones above the window size.
    always_comb begin
        range_in   = wdata[RANGE_LSB +: RANGE_W];
        start_next = {ADDR_W{1'b1}} << (MIN_WIN_LOG2 + int'(range_in));
    end

    // Register storage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            base_q  <= '0;
            start_q <= '0;
        end else if (we) begin
            if (sel == SEL_CTRL) begin
                ctrl_q  <= wdata;
                start_q <= start_next;
            end else if (sel == SEL_BASE) begin
                base_q  <= wdata;
            end
        end
    end

    // Read mux; unmapped words read zero.
    always_comb begin
        unique case (sel)
            SEL_CTRL: rdata = ctrl_q;
            SEL_BASE: rdata = base_q;
            default:  rdata = '0;
        endcase
    end

    assign base_o      = base_q;
    assign win_start_o = start_q;
endmodule

// File: rtl/iova_entry_addr.sv
// Table entry address former (combinational). Clears the window-start bits
// of the virtual address, scales the page index to a 4-byte entry offset and
// adds the table byte address (base shifted left).
module iova_entry_addr #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int BASE_SHIFT = 4,
    parameter int ENTRY_LOG2 = 2
) (
    input  logic [DATA_W-1:0] base,
    input  logic [ADDR_W-1:0] win_start,
    input  logic [ADDR_W-1:0] va,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int                IDX_SHIFT  = PAGE_SHIFT - ENTRY_LOG2;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << ENTRY_LOG2) - 1);

    logic [ADDR_W-1:0] table_addr;
    logic [ADDR_W-1:0] rel_va;
    logic [ADDR_W-1:0] entry_off;

    // Combine table origin with the aligned page offset.
    always_comb begin
        table_addr = ADDR_W'(base) << BASE_SHIFT;
        rel_va     = va & ~win_start;
        entry_off  = (rel_va >> IDX_SHIFT) & ALIGN_MASK;
        entry_addr = table_addr + entry_off;
    end
endmodule

// File: rtl/iova_pa_form.sv
// Physical address former (combinational). Restores entry byte order when
// the memory port is little-endian, keeps only the page-number field, moves
// it to the page position and adds the page offset.
module iova_pa_form #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int PAGE_SHIFT  = 12,
    parameter int PPN_LSB     = 8,
    parameter int PPN_W       = 19,
    parameter bit MEM_PORT_LE = 1'b1
) (
    input  logic [DATA_W-1:0]     raw,
    input  logic [PAGE_SHIFT-1:0] page_off,
    output logic [ADDR_W-1:0]     pa
);
    localparam int                NBYTES   = DATA_W / 8;
    localparam logic [DATA_W-1:0] PPN_MASK = DATA_W'(((64'd1 << PPN_W) - 64'd1) << PPN_LSB);

    logic [DATA_W-1:0] entry;
    logic [DATA_W-1:0] ppn_field;

    // Byte order fix-up chosen by the port endianness.
    generate
        if (MEM_PORT_LE) begin : g_swap
            for (genvar b = 0; b < NBYTES; b++) begin : g_byte
                assign entry[8*b +: 8] = raw[8*(NBYTES-1-b) +: 8];
            end
        end else begin : g_pass
            assign entry = raw;
        end
    endgenerate

    // Place the page number and add the offset inside the page.
    always_comb begin
        ppn_field = entry & PPN_MASK;
        pa        = (ADDR_W'(ppn_field >> PPN_LSB) << PAGE_SHIFT) + ADDR_W'(page_off);
    end
endmodule

// File: rtl/iova_walk_fsm.sv
// Walk sequencer: accepts one request, issues one entry read, waits for the
// data and presents a one-cycle response. Assumes read data arrives no
// sooner than the cycle after the read request.
module iova_walk_fsm #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     entry_addr_in,
    input  logic [PAGE_SHIFT-1:0] va_off_in,
    input  logic [ADDR_W-1:0]     pa_in,
    input  logic                  mem_rvalid,
    output logic                  req_ready,
    output logic                  mem_req,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [PAGE_SHIFT-1:0] va_off,
    output logic                  rsp_valid,
    output logic [ADDR_W-1:0]     rsp_pa
);
    import iova_pkg::*;

    walk_state_e           state_q;
    logic [ADDR_W-1:0]     addr_q;
    logic [PAGE_SHIFT-1:0] off_q;
    logic [ADDR_W-1:0]     pa_q;

    // State advance and capture of walk operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            off_q   <= '0;
            pa_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    addr_q  <= entry_addr_in;
                    off_q   <= va_off_in;
                    state_q <= ST_ISSUE;
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: if (mem_rvalid) begin
                    pa_q    <= pa_in;
                    state_q <= ST_RESP;
                end
                ST_RESP: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the walk state.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_req   = (state_q == ST_ISSUE);
        rsp_valid = (state_q == ST_RESP);
        mem_addr  = addr_q;
        va_off    = off_q;
        rsp_pa    = pa_q;
    end
endmodule

// File: rtl/iova_xlate.sv
// Top of the IO virtual address translator: register port, entry address
// former, physical address former and walk sequencer. One translation is
// outstanding at a time.
module iova_xlate #(
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 32,
    parameter int SEL_W        = 2,
    parameter int PAGE_SHIFT   = 12,
    parameter int BASE_SHIFT   = 4,
    parameter int RANGE_LSB    = 2,
    parameter int RANGE_W      = 3,
    parameter int MIN_WIN_LOG2 = 24,
    parameter int PPN_LSB      = 8,
    parameter int PPN_W        = 19,
    parameter bit MEM_PORT_LE  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_va,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_pa,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [DATA_W-1:0]     base_w;
    logic [ADDR_W-1:0]     start_w;
    logic [ADDR_W-1:0]     entry_addr_w;
    logic [PAGE_SHIFT-1:0] off_w;
    logic [ADDR_W-1:0]     pa_w;

    iova_cfg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
        .RANGE_LSB(RANGE_LSB), .RANGE_W(RANGE_W), .MIN_WIN_LOG2(MIN_WIN_LOG2)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata),
        .base_o(base_w), .win_start_o(start_w)
    );

    iova_entry_addr #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT),
        .BASE_SHIFT(BASE_SHIFT), .ENTRY_LOG2(2)
    ) u_eaddr (
        .base(base_w), .win_start(start_w), .va(req_va),
        .entry_addr(entry_addr_w)
    );

    iova_pa_form #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT),
        .PPN_LSB(PPN_LSB), .PPN_W(PPN_W), .MEM_PORT_LE(MEM_PORT_LE)
    ) u_pa (
        .raw(mem_rdata), .page_off(off_w), .pa(pa_w)
    );

    iova_walk_fsm #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .entry_addr_in(entry_addr_w), .va_off_in(req_va[PAGE_SHIFT-1:0]),
        .pa_in(pa_w), .mem_rvalid(mem_rvalid),
        .req_ready(req_ready), .mem_req(mem_req), .mem_addr(mem_addr),
        .va_off(off_w), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa)
    );
endmodule

// File: rtl/iova_xlate_chk.sv
// Protocol checker for the translator, bound to every instance of the top.
module iova_xlate_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req,
    input logic              mem_rvalid,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_pa
);
    // R7
    busy_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || rsp_valid) |-> !req_ready);

    // R4
    accept_issues_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_req);

    // R4
    read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R7
    data_not_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid) |=> !rsp_valid);

    // R6
    pa_top_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !rsp_pa[ADDR_W-1]);
endmodule

bind iova_xlate iova_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mem_req(mem_req), .mem_rvalid(mem_rvalid), .rsp_valid(rsp_valid),
    .rsp_pa(rsp_pa)
);

// File: tb/iova_xlate_test.sv
module iova_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    // Model state: what the bench believes the registers hold.
    logic [31:0] m_ctrl = '0;
    logic [31:0] m_base = '0;

    always #10 clk = ~clk;

    iova_xlate uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // Vectors: {control, base, virtual address, memory latency}
    localparam logic [103:0] VEC [0:7] = '{
        {32'h0000_0001, 32'h0001_2340, 32'hFF34_5678, 8'd1},
        {32'h0000_001D, 32'h0010_0000, 32'h80AB_C123, 8'd3},
        {32'h0000_0005, 32'h0000_FFF0, 32'hFE7F_F004, 8'd2},
        {32'h0000_000C, 32'h0020_0001, 32'hFFFF_FFFF, 8'd5},
        {32'h0000_0011, 32'h0ABC_DEF0, 32'hF000_0000, 8'd1},
        {32'h0000_0018, 32'h0000_0000, 32'h1234_5000, 8'd4},
        {32'h0000_0014, 32'h0FFF_FFFF, 32'hE000_1ABC, 8'd2},
        {32'h0000_0009, 32'h0000_0100, 32'hFDFF_F000, 8'd7}
    };

    function automatic logic [31:0] win_start(input logic [31:0] ctrl);
        return 32'hFFFF_FFFF << (24 + int'(ctrl[4:2]));
    endfunction

    function automatic logic [31:0] entry_of(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'hF800_00A5;
    endfunction

    function automatic logic [31:0] bswap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == 2'd0) m_ctrl = d;
        if (a == 2'd1) m_base = d;
    endtask

    task automatic cfg_read(input logic [1:0] a, input logic [31:0] exp, input string req);
        cfg_addr = a;
        #1;
        chk(cfg_rdata == exp, req, cfg_rdata, exp);
    endtask

    task automatic translate(input logic [31:0] va, input int lat);
        logic [31:0] ws, ea, ent, pa;
        ws  = (m_ctrl == 32'd0 && m_base == 32'd0 && !rst_n) ? 32'd0 : 32'd0;
        ws  = win_start_valid ? win_start(m_ctrl) : 32'd0;
        ea  = (m_base << 4) + (((va & ~ws) >> 10) & ~32'd3);
        ent = entry_of(ea);
        pa  = ((ent & 32'h07FF_FF00) << 4) + (va & 32'hFFF);
        @(negedge clk);
        chk(req_ready == 1'b1, "R7 ready idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_va = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_req == 1'b1, "R4 mem_req", 32'(mem_req), 32'd1);
        chk(mem_addr == ea, "R4 R3 entry address", mem_addr, ea);
        chk(req_ready == 1'b0, "R7 busy", 32'(req_ready), 32'd0);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk(!mem_req && !req_ready && !rsp_valid, "R7 wait",
                {29'd0, mem_req, req_ready, rsp_valid}, 32'd0);
        end
        mem_rvalid = 1'b1; mem_rdata = bswap(ent);
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
        chk(rsp_valid == 1'b1, "R8 rsp_valid", 32'(rsp_valid), 32'd1);
        chk(rsp_pa == pa, "R5 R6 physical address", rsp_pa, pa);
        chk(req_ready == 1'b0, "R7 ready in resp", 32'(req_ready), 32'd0);
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R8 pulse end", {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    // Window start is zero until a control write after reset.
    bit win_start_valid = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        cfg_read(2'd0, 32'd0, "R1 ctrl after reset");
        cfg_read(2'd1, 32'd0, "R1 base after reset");
        chk(req_ready && !rsp_valid && !mem_req, "R1 outputs after reset",
            {29'd0, req_ready, rsp_valid, mem_req}, 32'd4);
        // R1 window start zero: no bits cleared
        translate(32'hC000_1234, 1);

        // Vector walk
        for (int v = 0; v < 8; v++) begin
            cfg_write(2'd0, VEC[v][103:72]);
            win_start_valid = 1'b1;
            cfg_write(2'd1, VEC[v][71:40]);
            cfg_read(2'd0, VEC[v][103:72], "R2 ctrl readback");
            cfg_read(2'd1, VEC[v][71:40], "R2 base readback");
            translate(VEC[v][39:8], int'(VEC[v][7:0]));
        end

        // R2 unmapped words ignored
        cfg_write(2'd2, 32'h1234_5678);
        cfg_write(2'd3, 32'hFFFF_FFFF);
        cfg_read(2'd2, 32'd0, "R2 word2 reads zero");
        cfg_read(2'd3, 32'd0, "R2 word3 reads zero");
        cfg_read(2'd0, m_ctrl, "R2 ctrl untouched");
        cfg_read(2'd1, m_base, "R2 base untouched");

        // R3 range code 7 gives 0x80000000; request right after the write
        cfg_write(2'd0, 32'h0000_001C);
        translate(32'hFFFF_F800, 1);
        // R3 range code 0 gives 0xFF000000
        cfg_write(2'd0, 32'h0000_0000);
        translate(32'hFFAB_CDEF, 2);

        // R7 request held high while busy: only one read issued
        @(negedge clk);
        req_valid = 1'b1; req_va = 32'h0000_5000;
        @(negedge clk);
        repeat (3) begin
            @(negedge clk);
            chk(!mem_req && !req_ready, "R7 held request not re-accepted",
                {30'd0, mem_req, req_ready}, 32'd0);
        end
        req_valid = 1'b0;
        mem_rvalid = 1'b1; mem_rdata = 32'd0;
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk(rsp_valid == 1'b1, "R8 held request response", 32'(rsp_valid), 32'd1);
        @(negedge clk);

        // R1 reset after configuration clears registers and window start
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_ctrl = '0; m_base = '0; win_start_valid = 1'b0;
        cfg_read(2'd0, 32'd0, "R1 ctrl after second reset");
        cfg_read(2'd1, 32'd0, "R1 base after second reset");
        translate(32'hFFFF_0ABC, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule